// File: doc/BRIEF.md
# External Bus Hold Controller

This block lets another bus master, such as a DMA engine or a second processor, take the external bus away from the local core. The other master pulls an active-low, asynchronous hold request. The block synchronizes the request and stalls new bus cycle starts. It waits until the bus sequencer reports no cycle in flight and no indivisible access pair open. Then it disables the address/data and strobe output drivers and pulls the active-low acknowledge. When the request is withdrawn, the block first raises the acknowledge and turns the drivers back on. It keeps the stall for one more clock before cycle starts may resume.

The block is gated in two ways. The port pins must be put in their control role, and the power-save mode must allow it. In HALT the core issues no bus cycles, so the block grants hold at once without waiting for bus idle. In STOP and IDLE the clock is stopped in the real system, so any request is ignored. The core keeps executing internally during hold. Only its next external access waits, through the stall-start output toward the sequencer.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset, hold_ack_no is 1, bus_oe_o is 1 and stall_start_o is 0.
- R2: While pin_ctl_en_i is 0, requests are ignored: hold_ack_no stays 1 and stall_start_o stays 0.
- R3: In the held state, hold_ack_no is 0, bus_oe_o is 0 (bus and strobes high impedance) and stall_start_o is 1, all at the same time.
- R4: In run mode (pwr_mode_i = 2'b00), an accepted request first raises stall_start_o. Hold is granted only on the clock after one in which bus_cycle_i is 0 and locked_i is 0.
- R5: While locked_i is 1 (between the halves of a split word access or the read and write of a read-modify-write), hold is not granted.
- R6: Release order: the request going high causes hold_ack_no = 1 and bus_oe_o = 1 with stall_start_o still 1 for exactly one clock. stall_start_o returns to 0 on the next clock.
- R7: In STOP (2'b10) or IDLE (2'b11) mode, a request produces no hold and no stall.
- R8: In HALT mode (2'b01), hold is granted directly on the clock the synchronized request is seen, whatever bus_cycle_i and locked_i show.
- R9: hold_req_ni passes through a two-flop synchronizer. A level applied before clock edge 1 changes the state machine on edge 3, and the outputs are unchanged after edge 2.
- R10: A request that is low for only one clock in HALT still gives exactly one clock of hold_ack_no = 0.
- R11: A request withdrawn while waiting for bus idle returns to normal without ever pulling hold_ack_no low.
- R12: Clearing pin_ctl_en_i while held ends the hold through the same release order as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_ctl_en_i | input | 1 | Hold pins in control role |
| pwr_mode_i | input | 2 | 00 run, 01 halt, 10 stop, 11 idle |
| hold_req_ni | input | 1 | Asynchronous hold request, active low |
| bus_cycle_i | input | 1 | Sequencer has a bus cycle in flight |
| locked_i | input | 1 | Inside an indivisible access pair |
| hold_ack_no | output | 1 | Hold acknowledge, active low |
| bus_oe_o | output | 1 | 1 drives bus and strobes, 0 releases them |
| stall_start_o | output | 1 | Holds off new bus cycle starts |

## Verification
The assertions check on every cycle that hold never begins while a cycle or locked pair is open in run mode. They also check that acknowledge implies stall, that stall never clears before acknowledge has risen, and that disabled or sleeping modes never start a hold. The synchronizer latency, the instant grant in HALT, the single-clock pulse, withdrawal while pending and the enable drop during hold can only be shown by the bench's timed scenarios. These run across every combination of enable, power mode, busy length and lock.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_HALT = 2'b01,
    PM_STOP = 2'b10,
    PM_IDLE = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    HS_NORMAL,
    HS_PEND,
    HS_HOLD,
    HS_REL
  } hold_state_e;
endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic req_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], ~req_ni};
  end

  assign req_o = sh_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  pwr_mode_e mode_i,
  input  logic      req_i,
  input  logic      bus_cycle_i,
  input  logic      locked_i,
  output logic      ack_no,
  output logic      oe_o,
  output logic      stall_o
);
  hold_state_e st_q, st_d;
  logic req_eff, awake, bus_quiet;

  assign req_eff   = req_i & en_i;
  assign awake     = (mode_i == PM_RUN) | (mode_i == PM_HALT);
  assign bus_quiet = ~bus_cycle_i & ~locked_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_NORMAL:
        if (req_eff && mode_i == PM_HALT)     st_d = HS_HOLD;
        else if (req_eff && mode_i == PM_RUN) st_d = HS_PEND;
      HS_PEND:
        if (!req_eff)                  st_d = HS_NORMAL;
        else if (awake && (bus_quiet || mode_i == PM_HALT)) st_d = HS_HOLD;
      HS_HOLD:
        if (!req_eff) st_d = HS_REL;
      HS_REL:
        st_d = HS_NORMAL;
      default: st_d = HS_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= HS_NORMAL;
    else         st_q <= st_d;
  end

  assign ack_no  = (st_q != HS_HOLD);
  assign oe_o    = (st_q != HS_HOLD);
  assign stall_o = (st_q != HS_NORMAL);

  a_r2_disabled_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ack_no);
  a_r3_hold_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> stall_o && !oe_o);
  a_r4_grant_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ack_no) && $past(mode_i) == PM_RUN) |-> $past(stall_o && !bus_cycle_i && !locked_i));
  a_r5_locked_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_no && locked_i && mode_i == PM_RUN) |=> ack_no);
  a_r6_stall_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> $past(ack_no));
  a_r7_sleep_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_no && (mode_i == PM_STOP || mode_i == PM_IDLE)) |=> ack_no);
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_ctl_en_i,
  input  logic [1:0] pwr_mode_i,
  input  logic       hold_req_ni,
  input  logic       bus_cycle_i,
  input  logic       locked_i,
  output logic       hold_ack_no,
  output logic       bus_oe_o,
  output logic       stall_start_o
);
  logic req_sync;

  hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (hold_req_ni),
    .req_o  (req_sync)
  );

  hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (pin_ctl_en_i),
    .mode_i      (pwr_mode_e'(pwr_mode_i)),
    .req_i       (req_sync),
    .bus_cycle_i (bus_cycle_i),
    .locked_i    (locked_i),
    .ack_no      (hold_ack_no),
    .oe_o        (bus_oe_o),
    .stall_o     (stall_start_o)
  );
endmodule

// File: tb/sim_bus_hold_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hold_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, req_n = 1'b1, cyc = 1'b0, lk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ack_n, oe, stall;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bus_hold_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_ctl_en_i(en), .pwr_mode_i(mode),
    .hold_req_ni(req_n), .bus_cycle_i(cyc), .locked_i(lk),
    .hold_ack_no(ack_n), .bus_oe_o(oe), .stall_start_o(stall)
  );

  localparam logic [2:0] NORM = 3'b110, PEND = 3'b111, HOLD = 3'b001, REL = 3'b111;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(input string tag, input logic [2:0] exp);
    n_chk++;
    if ({ack_n, oe, stall} !== exp) begin
      n_bad++;
      $display("FAIL %s: {ack_n,oe,stall} got %b expected %b (en=%b mode=%0d)",
               tag, {ack_n, oe, stall}, exp, en, mode);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", NORM);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset", NORM);

    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 3; b++)
          for (int l = 0; l < 2; l++) begin
            bit act;
            en = e[0]; mode = m[1:0];
            cyc = (b > 0); lk = l[0];
            act = e[0] && (m < 2);
            req_n = 1'b0;
            step(2);
            chk("R9 not yet seen", NORM);
            step(1);
            if (!act)        chk(e ? "R7 sleep ignores" : "R2 disabled ignores", NORM);
            else if (m == 1) chk("R8 halt grants at once", HOLD);
            else begin
              chk("R4 stall first", PEND);
              for (int k = 0; k < b; k++) begin
                step(1); chk("R4 waits for cycle end", PEND);
              end
              cyc = 1'b0;
              if (l) begin step(1); chk("R5 locked blocks", PEND); end
              lk = 1'b0;
              step(1);
              chk("R3 R4 held", HOLD);
            end
            step(2);
            if (act) chk("R3 hold persists", HOLD);
            else     chk("R2 R7 still normal", NORM);
            req_n = 1'b1;
            step(3);
            if (act) chk("R6 ack up stall kept", REL);
            else     chk("R2 R7 release idle", NORM);
            step(1);
            chk("R6 stall cleared", NORM);
            cyc = 1'b0; lk = 1'b0;
            step(2);
          end

    // R10: one-clock pulse in halt
    en = 1'b1; mode = 2'b01;
    req_n = 1'b0; step(1); req_n = 1'b1;
    step(2); chk("R10 pulse granted", HOLD);
    step(1); chk("R10 one clock only", REL);
    step(1); chk("R10 back to normal", NORM);
    step(2);

    // R11: withdraw while pending
    mode = 2'b00; cyc = 1'b1;
    req_n = 1'b0; step(3); chk("R11 pending", PEND);
    req_n = 1'b1; step(2); chk("R11 still pending in sync", PEND);
    step(1); chk("R11 withdrawn no ack", NORM);
    cyc = 1'b0; step(2);

    // R12: enable dropped while held
    req_n = 1'b0; step(4); chk("R12 held", HOLD);
    en = 1'b0; step(1); chk("R12 release order", REL);
    step(1); chk("R12 normal", NORM);
    req_n = 1'b1; step(4); chk("R2 disabled stays normal", NORM);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule